// File: doc/BRIEF.md
# Command/Indication Channel Transceiver

The block carries a short command/indication code in one fixed field of every frame, in both directions. A controller writes code words into a transmit register. The transmit side puts each word on the line for at least two consecutive frames. When no newer word is waiting, it keeps sending the last word. A transmit-empty flag tells the controller when another word may be written.

The receive side samples the incoming field once per frame, at the frame strobe. A code word counts as valid only when two consecutive frames carry the same value. A code that differs from the buffered one is stored and marks the buffer not yet valid. A second frame with the same code sets the receive-full flag. Reading the receive register has no side effect. The controller has about one frame period to pick up a valid code before a new one may replace it.

Frame timing comes from an external one-cycle strobe. The code width and the minimum number of frames per transmitted word are parameters. Their defaults are 4 bits and 2 frames.

Top module: `cic_xcvr`

## Requirements
- R1: While reset is asserted, and after reset, the block shows tx_code = all-ones, tx_obe = 1, rx_rdata = all-ones and rx_ibf = 0.
- R2: A write pulse on tx_wr clears tx_obe in the next cycle.
- R3: tx_code changes only in the cycle after a frame_stb. When the line is idle, a pending word appears on tx_code in the cycle after the first frame_stb that follows the write.
- R4: A word written while the current word has completed fewer than two frames stays pending. It replaces the current word only at the strobe that ends the current word's second frame.
- R5: With no word pending, tx_code keeps repeating the last word at every later strobe.
- R6: tx_obe rises only after a frame_stb, at the second strobe after the strobe that loaded the last pending word.
- R7: At a frame_stb where rx_code differs from rx_rdata, rx_rdata takes the sampled code in the next cycle and rx_ibf is 0.
- R8: At a frame_stb where rx_code equals rx_rdata, rx_ibf is 1 in the next cycle.
- R9: Between strobes, rx_rdata and rx_ibf hold their values whatever rx_code does.
- R10: If two writes arrive before the pending word is loaded, only the later word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_stb | input | 1 | One-cycle pulse at each frame boundary |
| tx_wr | input | 1 | Controller write strobe for the transmit register |
| tx_wdata | input | CODE_W | Code word to transmit |
| tx_code | output | CODE_W | Code placed in the frame field |
| tx_obe | output | 1 | Transmit register empty: the last word has been sent in two frames |
| rx_code | input | CODE_W | Code received in the frame field |
| rx_rdata | output | CODE_W | Receive buffer contents |
| rx_ibf | output | 1 | Receive buffer valid: the same code arrived in two consecutive frames |

## Verification
Every result of this block is registered exactly once. tx_obe responds one cycle after a write. tx_code, tx_obe, rx_rdata and rx_ibf respond one cycle after the frame strobe that triggers them. For each frame, the driver queues the expected line code and flags before it raises the strobe. The monitor pops that entry at the falling edge that follows the strobe's rising edge, which is the first point where the registered results are settled. Checks on the write response and on ignored rx_code changes are made at the falling edge after the stimulus, before any further strobe.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int CIC_DEF_CODE_W     = 4;
  localparam int CIC_DEF_MIN_FRAMES = 2;
  localparam int CIC_SYNC_STAGES    = 2;
endpackage

// File: rtl/cic_rst_sync.sv
module cic_rst_sync #(
  parameter int STAGES = cic_pkg::CIC_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cic_tx.sv
module cic_tx #(
  parameter int CODE_W     = cic_pkg::CIC_DEF_CODE_W,
  parameter int MIN_FRAMES = cic_pkg::CIC_DEF_MIN_FRAMES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic              wr,
  input  logic [CODE_W-1:0] wdata,
  output logic [CODE_W-1:0] code,
  output logic              obe
);
  localparam int CNT_W = $clog2(MIN_FRAMES + 1);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(MIN_FRAMES);

  logic [CODE_W-1:0] cur_q, cur_d, pend_q, pend_d;
  logic              pend_v_q, pend_v_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic              load;

  // frames completed by the word on the line, saturating at DONE
  always_comb begin
    cnt_inc  = (cnt_q >= DONE) ? DONE : cnt_q + 1'b1;
    load     = frame_stb && pend_v_q && (cnt_inc >= DONE);
    cur_d    = load ? pend_q : cur_q;
    cnt_d    = load ? '0 : cnt_inc;
    pend_d   = wr ? wdata : pend_q;
    pend_v_d = wr ? 1'b1 : (load ? 1'b0 : pend_v_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '1;
      cnt_q    <= DONE;
      pend_q   <= '1;
      pend_v_q <= 1'b0;
    end else begin
      if (frame_stb) begin
        cur_q <= cur_d;
        cnt_q <= cnt_d;
      end
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
    end
  end

  assign code = cur_q;
  assign obe  = !pend_v_q && (cnt_q >= DONE);
endmodule

// File: rtl/cic_rx.sv
module cic_rx #(
  parameter int CODE_W = cic_pkg::CIC_DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] rdata,
  output logic              ibf
);
  logic [CODE_W-1:0] buf_q, buf_d;
  logic              ibf_q, ibf_d;
  logic              same;

  always_comb begin
    same  = (code == buf_q);
    buf_d = same ? buf_q : code;
    ibf_d = same;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '1;
      ibf_q <= 1'b0;
    end else if (frame_stb) begin
      buf_q <= buf_d;
      ibf_q <= ibf_d;
    end
  end

  assign rdata = buf_q;
  assign ibf   = ibf_q;
endmodule

// File: rtl/cic_xcvr.sv
module cic_xcvr #(
  parameter int CODE_W     = cic_pkg::CIC_DEF_CODE_W,
  parameter int MIN_FRAMES = cic_pkg::CIC_DEF_MIN_FRAMES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic              tx_wr,
  input  logic [CODE_W-1:0] tx_wdata,
  output logic [CODE_W-1:0] tx_code,
  output logic              tx_obe,
  input  logic [CODE_W-1:0] rx_code,
  output logic [CODE_W-1:0] rx_rdata,
  output logic              rx_ibf
);
  logic rst_sync_n;

  cic_rst_sync #(.STAGES(cic_pkg::CIC_SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cic_tx #(.CODE_W(CODE_W), .MIN_FRAMES(MIN_FRAMES)) u_tx (
    .clk(clk), .rst_n(rst_sync_n), .frame_stb(frame_stb),
    .wr(tx_wr), .wdata(tx_wdata), .code(tx_code), .obe(tx_obe)
  );

  cic_rx #(.CODE_W(CODE_W)) u_rx (
    .clk(clk), .rst_n(rst_sync_n), .frame_stb(frame_stb),
    .code(rx_code), .rdata(rx_rdata), .ibf(rx_ibf)
  );
endmodule

// File: rtl/cic_xcvr_chk.sv
module cic_xcvr_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_stb,
  input logic              tx_wr,
  input logic [CODE_W-1:0] tx_code,
  input logic              tx_obe,
  input logic [CODE_W-1:0] rx_code,
  input logic [CODE_W-1:0] rx_rdata,
  input logic              rx_ibf
);
  // R2
  wr_clears_obe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tx_obe);

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(tx_code));

  // R6
  obe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_obe) |-> $past(frame_stb));

  // R7
  rx_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && rx_code != rx_rdata) |=> (!rx_ibf && rx_rdata == $past(rx_code)));

  // R8
  rx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && rx_code == rx_rdata) |=> rx_ibf);

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(rx_rdata) && $stable(rx_ibf)));
endmodule

bind cic_xcvr cic_xcvr_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .tx_wr(tx_wr),
  .tx_code(tx_code), .tx_obe(tx_obe), .rx_code(rx_code),
  .rx_rdata(rx_rdata), .rx_ibf(rx_ibf)
);

// File: tb/cic_xcvr_bench.sv
module cic_xcvr_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_stb = 1'b0;
  logic         tx_wr = 1'b0;
  logic [W-1:0] tx_wdata = '0;
  logic [W-1:0] rx_code = '1;
  logic [W-1:0] tx_code, rx_rdata;
  logic         tx_obe, rx_ibf;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    string        tag;
    logic [W-1:0] tx;
    logic         obe;
    logic [W-1:0] rd;
    logic         ibf;
  } exp_t;

  exp_t exp_q[$];

  always #4 clk = ~clk;

  cic_xcvr #(.CODE_W(W), .MIN_FRAMES(2)) u_cic_xcvr (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_code(tx_code), .tx_obe(tx_obe),
    .rx_code(rx_code), .rx_rdata(rx_rdata), .rx_ibf(rx_ibf)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [W-1:0] rxv, input logic [W-1:0] etx, input logic eobe,
                       input logic [W-1:0] erd, input logic eibf, input string tag);
    exp_t e;
    @(negedge clk);
    e.tag = tag; e.tx = etx; e.obe = eobe; e.rd = erd; e.ibf = eibf;
    exp_q.push_back(e);
    rx_code   = rxv;
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic write(input logic [W-1:0] v);
    @(negedge clk);
    tx_wr = 1'b1; tx_wdata = v;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  // monitor: results are due one cycle after the strobe edge
  always @(posedge clk) begin
    if (rst_n && frame_stb) begin
      exp_t e;
      @(negedge clk);
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL monitor: actual strobe expected none queued");
      end else begin
        e = exp_q.pop_front();
        chk({e.tag, " tx_code"},  tx_code,  e.tx);
        chk({e.tag, " tx_obe"},   W'(tx_obe), W'(e.obe));
        chk({e.tag, " rx_rdata"}, rx_rdata, e.rd);
        chk({e.tag, " rx_ibf"},   W'(rx_ibf), W'(e.ibf));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 tx_code in reset", tx_code, 4'hF);
    chk("R1 obe in reset", W'(tx_obe), W'(1));
    chk("R1 rdata in reset", rx_rdata, 4'hF);
    chk("R1 ibf in reset", W'(rx_ibf), W'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 obe after reset", W'(tx_obe), W'(1));
    chk("R1 ibf after reset", W'(rx_ibf), W'(0));

    write(4'h5);
    chk("R2 obe after write", W'(tx_obe), W'(0));
    frame(4'h3, 4'h5, 1'b0, 4'h3, 1'b0, "R3 idle load / R7 mismatch");
    frame(4'h3, 4'h5, 1'b0, 4'h3, 1'b1, "R8 match");
    write(4'hA);
    frame(4'h3, 4'hA, 1'b0, 4'h3, 1'b1, "R4 load after two frames");
    write(4'h6);
    frame(4'h7, 4'hA, 1'b0, 4'h7, 1'b0, "R4 held first frame / R7");
    frame(4'h7, 4'h6, 1'b0, 4'h7, 1'b1, "R4 load at second / R8");
    frame(4'h7, 4'h6, 1'b0, 4'h7, 1'b1, "R6 not yet empty");
    frame(4'h2, 4'h6, 1'b1, 4'h2, 1'b0, "R6 empty after second frame");
    frame(4'h2, 4'h6, 1'b1, 4'h2, 1'b1, "R5 repeat last word");

    // R9: rx_code changes without a strobe have no effect
    @(negedge clk); rx_code = 4'h9;
    repeat (3) @(negedge clk);
    chk("R9 rdata held", rx_rdata, 4'h2);
    chk("R9 ibf held", W'(rx_ibf), W'(1));
    chk("R5 tx held between strobes", tx_code, 4'h6);

    // R10: second write replaces the pending word
    write(4'h1);
    write(4'h2);
    frame(4'h9, 4'h2, 1'b0, 4'h9, 1'b0, "R10 later write sent");
    frame(4'h9, 4'h2, 1'b0, 4'h9, 1'b1, "R10 held / R8");
    frame(4'h9, 4'h2, 1'b1, 4'h9, 1'b1, "R6 empty again");

    repeat (5) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL monitor drain: actual %0d expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule